// File: doc/BRIEF.md
# Lockable Watchdog with Read-Clear

This block is a watchdog for a small controller. A three-bit counter advances once on each pulse of one tap of an external prescaler. When it wraps from its highest value back to zero, the block raises a reset request for the system reset controller. Software keeps the request from firing by reading a clear register. That read access returns the counter to zero.

A control word selects which prescaler tap feeds the counter, switches the watchdog on and off, and can lock it. While unlocked, software may start and stop the watchdog freely. Once locked, the watchdog is forced on and ignores all further control writes until the next system reset. After reset the watchdog is idle until software enables it. The prescaler and the stretching of the reset pulse are outside the block. The taps arrive as single-cycle strobes in the block's clock domain.

Top module: `wdog_lockable`

## Requirements
- R1: After system reset the watchdog is disabled and unlocked, its tap select is 0, and no reset request is raised even if taps pulse.
- R2: The control word has the lock flag in bit 3 and the run flag in bit 2. Bits 1:0 hold a tap index n, which makes `tap_i[n]` the counting source.
- R3: While running, the counter advances by one in every cycle in which the selected tap is high. Pulses on unselected taps have no effect.
- R4: The eighth counted pulse after a zero count wraps the counter to zero. `wdg_rst_o` is then high for exactly one cycle, in the cycle after that pulse, and another eight pulses are needed for the next request.
- R5: A cycle with `clr_rd_i` high returns the counter to zero.
- R6: When a clear read and a selected tap pulse occur in the same cycle, the clear wins and the count becomes zero.
- R7: While the watchdog is disabled the counter is held at zero, so after re-enabling a full eight pulses are needed.
- R8: While unlocked, a control write takes effect from the next cycle and may disable a running watchdog.
- R9: Writing the lock flag as 1 also forces the run flag on, whatever bit 2 holds.
- R10: Once locked, control writes are ignored: they cannot clear the run flag, clear the lock or change the tap select.
- R11: Only a system reset releases the lock and returns the watchdog to the disabled state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low system reset, released synchronously inside |
| tap_i | input | 4 | Prescaler tap strobes, one cycle high per tap pulse |
| ctl_wr_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 4 | Control write data: lock, run, tap select |
| clr_rd_i | input | 1 | Read strobe of the clear register |
| wdg_rst_o | output | 1 | Watchdog reset request, one cycle wide |

## Verification
The counting path is tried with pulses on the selected tap alone and with pulses on an unselected tap mixed in. This tells a correct tap decode apart from one that counts any tap. Counts are stopped short by a clear read, by a clear that coincides with a pulse, and by a disable/re-enable. Each pattern shows whether a request comes on the exact eighth pulse or one pulse early or late. The lock is tested by writing the disable, unlock and tap-change patterns after locking and then checking that the request still arrives on the old tap's schedule. A reset then shows that the lock is gone.

// File: rtl/wdog_lk_pkg.sv
package wdog_lk_pkg;
  localparam int unsigned TAP_N = 4;
  localparam int unsigned SEL_W = $clog2(TAP_N);
  localparam int unsigned CTL_W = SEL_W + 2;

  typedef struct packed {
    logic             lock;
    logic             run;
    logic [SEL_W-1:0] sel;
  } ctl_t;
endpackage

// File: rtl/wdog_lk_rsync.sv
module wdog_lk_rsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_no = sync_q[STAGES-1];
endmodule

// File: rtl/wdog_lk_ctl.sv
module wdog_lk_ctl
  import wdog_lk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output ctl_t             ctl_o
);
  ctl_t ctl_q;
  ctl_t ctl_d;
  logic ctl_we;

  // writes accepted only while unlocked; lock forces run
  always_comb begin
    ctl_we     = wr_i & ~ctl_q.lock;
    ctl_d      = ctl_t'(wdata_i);
    ctl_d.run  = wdata_i[CTL_W-2] | wdata_i[CTL_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_d;
  end

  assign ctl_o = ctl_q;
endmodule

// File: rtl/wdog_lk_tapsel.sv
module wdog_lk_tapsel
  import wdog_lk_pkg::*;
(
  input  logic [TAP_N-1:0] tap_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [TAP_N-1:0] hit;

  for (genvar g = 0; g < TAP_N; g++) begin : g_tap
    assign hit[g] = tap_i[g] & (sel_i == SEL_W'(g));
  end

  assign tick_o = |hit;
endmodule

// File: rtl/wdog_lk_cnt.sv
module wdog_lk_cnt #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_we;
  logic             ovf_q;
  logic             ovf_d;

  // priority: disabled hold, then clear read, then counting pulse
  always_comb begin
    cnt_d  = cnt_q;
    cnt_we = 1'b0;
    ovf_d  = 1'b0;
    if (!run_i) begin
      cnt_d  = '0;
      cnt_we = 1'b1;
    end else if (clr_i) begin
      cnt_d  = '0;
      cnt_we = 1'b1;
    end else if (tick_i) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_we = 1'b1;
      ovf_d  = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= 1'b0;
    else         ovf_q <= ovf_d;
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/wdog_lockable.sv
module wdog_lockable
  import wdog_lk_pkg::*;
#(
  parameter int unsigned CNT_W       = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAP_N-1:0] tap_i,
  input  logic             ctl_wr_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             clr_rd_i,
  output logic             wdg_rst_o
);
  logic             srst_n;
  ctl_t             ctl;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  wdog_lk_rsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .srst_no (srst_n)
  );

  wdog_lk_ctl u_ctl (
    .clk_i   (clk_i),
    .rst_ni  (srst_n),
    .wr_i    (ctl_wr_i),
    .wdata_i (ctl_wdata_i),
    .ctl_o   (ctl)
  );

  wdog_lk_tapsel u_tapsel (
    .tap_i  (tap_i),
    .sel_i  (ctl.sel),
    .tick_o (tick)
  );

  wdog_lk_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (srst_n),
    .run_i  (ctl.run),
    .clr_i  (clr_rd_i),
    .tick_i (tick),
    .cnt_o  (cnt),
    .ovf_o  (wdg_rst_o)
  );
endmodule

// File: rtl/wdog_lockable_chk.sv
module wdog_lockable_chk #(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned SEL_W = 2
) (
  input logic             clk_i,
  input logic             srst_n,
  input logic             wdg_rst_o,
  input logic             clr_rd_i,
  input logic             tick,
  input logic             run,
  input logic             lock,
  input logic [SEL_W-1:0] sel,
  input logic [CNT_W-1:0] cnt
);
  // R4: request never lasts two cycles
  p_single_pulse_r4: assert property (@(posedge clk_i) disable iff (!srst_n)
    wdg_rst_o |=> !wdg_rst_o);

  // R4: request follows a counted pulse at full count
  p_req_cause_r4: assert property (@(posedge clk_i) disable iff (!srst_n)
    (run && !clr_rd_i && tick && (cnt == {CNT_W{1'b1}})) |=> (wdg_rst_o && cnt == '0));

  // R3: without a pulse or clear the count holds
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!srst_n)
    (run && !clr_rd_i && !tick) |=> $stable(cnt));

  // R6: clear read wins over a pulse
  p_clear_wins_r6: assert property (@(posedge clk_i) disable iff (!srst_n)
    clr_rd_i |=> (cnt == '0 && !wdg_rst_o));

  // R7: disabled counter is zero
  p_idle_zero_r7: assert property (@(posedge clk_i) disable iff (!srst_n)
    !run |=> (cnt == '0 && !wdg_rst_o));

  // R9 R10: lock sticks, keeps run and select
  p_lock_sticky_r10: assert property (@(posedge clk_i) disable iff (!srst_n)
    lock |=> (lock && run && $stable(sel)));
endmodule

bind wdog_lockable wdog_lockable_chk #(
  .CNT_W (CNT_W),
  .SEL_W (wdog_lk_pkg::SEL_W)
) u_chk (
  .clk_i     (clk_i),
  .srst_n    (srst_n),
  .wdg_rst_o (wdg_rst_o),
  .clr_rd_i  (clr_rd_i),
  .tick      (tick),
  .run       (ctl.run),
  .lock      (ctl.lock),
  .sel       (ctl.sel),
  .cnt       (cnt)
);

// File: tb/wdog_lockable_bench.sv
module wdog_lockable_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] tap;
  logic       wr;
  logic [3:0] wd;
  logic       clr;
  logic       req;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #5 clk = ~clk;

  wdog_lockable u_wdog_lockable (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .tap_i       (tap),
    .ctl_wr_i    (wr),
    .ctl_wdata_i (wd),
    .clr_rd_i    (clr),
    .wdg_rst_o   (req)
  );

  // {wr, wdata[3:0], clr, tap[3:0], expected request}
  localparam int NV = 21;
  localparam logic [10:0] VEC [NV] = '{
    11'b0_0000_0_0001_0, // R1 idle ignores taps
    11'b1_0101_0_0000_0, // R2 run, tap 1
    11'b0_0000_0_0001_0, // R3 other tap
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_1, // R4 eighth pulse
    11'b0_0000_0_0000_0, // R4 single cycle
    11'b1_0000_0_0000_0, // R8 disable
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0,
    11'b0_0000_0_0010_0  // R8 no request while off
  };

  task automatic check(input logic exp, input string tag);
    checks++;
    if (req !== exp) begin
      fails++;
      $display("FAIL %s: wdg_rst_o=%b expected=%b at %0t", tag, req, exp, $time);
    end
  endtask

  // called at a falling edge; drives, lets one rising edge pass, checks
  task automatic step(input logic w, input logic [3:0] d, input logic c,
                      input logic [3:0] t, input logic exp, input string tag);
    wr = w; wd = d; clr = c; tap = t;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; clr = 1'b0; tap = '0;
    check(exp, tag);
  endtask

  task automatic pulses(input int n, input logic [3:0] t, input logic last_exp,
                        input string tag);
    for (int i = 0; i < n; i++)
      step(1'b0, 4'h0, 1'b0, t, (i == n - 1) ? last_exp : 1'b0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: bench timed out, actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    wr = 1'b0; wd = '0; clr = 1'b0; tap = '0;
    @(negedge clk);
    do_reset();
    check(1'b0, "R1 after reset");

    for (int v = 0; v < NV; v++)
      step(VEC[v][10], VEC[v][9:6], VEC[v][5], VEC[v][4:1], VEC[v][0], "R3 R4 R8 table");

    // R5: clear read restarts the count, tap 3
    step(1'b1, 4'b0111, 1'b0, 4'h0, 1'b0, "R2 enable tap3");
    pulses(5, 4'b1000, 1'b0, "R5 partial");
    step(1'b0, 4'h0, 1'b1, 4'h0, 1'b0, "R5 clear");
    pulses(7, 4'b1000, 1'b0, "R5 seven after clear");
    pulses(1, 4'b1000, 1'b1, "R5 eighth after clear");

    // R6: clear and pulse together
    pulses(7, 4'b1000, 1'b0, "R6 to seven");
    step(1'b0, 4'h0, 1'b1, 4'b1000, 1'b0, "R6 clear wins");
    pulses(7, 4'b1000, 1'b0, "R6 seven after");
    pulses(1, 4'b1000, 1'b1, "R6 eighth after");

    // R7: disable holds at zero
    pulses(4, 4'b1000, 1'b0, "R7 partial");
    step(1'b1, 4'b0011, 1'b0, 4'h0, 1'b0, "R7 disable");
    step(1'b1, 4'b0111, 1'b0, 4'h0, 1'b0, "R7 re-enable");
    pulses(7, 4'b1000, 1'b0, "R7 seven after");
    pulses(1, 4'b1000, 1'b1, "R7 eighth after");

    // R9: lock with run bit clear, tap 1
    step(1'b1, 4'b1001, 1'b0, 4'h0, 1'b0, "R9 lock");
    pulses(7, 4'b0010, 1'b0, "R9 counting while locked");
    // R10: attempts to disable, unlock and move tap are ignored
    step(1'b1, 4'b0010, 1'b0, 4'h0, 1'b0, "R10 write ignored");
    pulses(3, 4'b0100, 1'b0, "R10 tap2 ignored");
    pulses(1, 4'b0010, 1'b1, "R10 still tap1");
    step(1'b1, 4'b0000, 1'b0, 4'h0, 1'b0, "R10 disable ignored");
    pulses(8, 4'b0010, 1'b1, "R10 still running");

    // R11: reset releases lock
    do_reset();
    pulses(8, 4'b1111, 1'b0, "R11 disabled after reset");
    step(1'b1, 4'b0100, 1'b0, 4'h0, 1'b0, "R11 writable again");
    pulses(8, 4'b0001, 1'b1, "R11 tap0 request");
    step(1'b1, 4'b0000, 1'b0, 4'h0, 1'b0, "R11 unlocked disable");
    pulses(8, 4'b0001, 1'b0, "R11 disable honoured");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule